// File: doc/BRIEF.md
# Dual-Register Output Macrocell

This block is one output logic cell of a small sum-of-products logic fabric. It receives two sum-term results from the array and holds two flip-flops. Each flip-flop can be set up on its own as a D-type or a toggle type. Each takes its clock from its own clock product term or from the shared dedicated clock pin, and each has its own asynchronous reset term. A single synchronous preset term is shared across the fabric. The cell drives one output pad through a polarity stage and an enable term. It also returns both register values and the pad level to the array on separate paths, so either register can be used as buried state.

All logic runs on the fabric's system clock `clk`. A register "clock edge" is any cycle in which its selected clock source is high and was low in the previous cycle. The register changes on the next `clk` rising edge. A test preload path copies the pad level into the register picked by a select input. Configuration inputs are meant to be held static while the cell runs.

Top module: `pldmc_top`

## Requirements
- R1: In D mode (`cfg_toggle[i]`=0), on a clock edge with no preset, preload or reset active, register i takes its data input. The data input of register 1 is `sum_term[1]`. The data input of register 0 is `sum_term[0]`, or `sum_term[0]|sum_term[1]` when `cfg_combine`=1.
- R2: In toggle mode (`cfg_toggle[i]`=1), on such a clock edge register i inverts when its data input is 1 and holds when it is 0.
- R3: The clock source of register i is `pin_clk` when `cfg_pin_clk[i]`=1 and `pt_clk[i]` when it is 0. An edge is a cycle where that source is 1 and was 0 in the previous cycle (0 is assumed before the first cycle after reset). With no edge and no reset, the register holds.
- R4: While `arst_pt[i]`=1, `fb_reg[i]` reads 0 in the same cycle and register i is cleared on the next `clk` edge. This reset wins over preset, preload and the clock.
- R5: `sync_preset`=1 sets register i to 1 only on a clock edge of that register, when preload and reset are inactive.
- R6: With `cfg_regout`=1 the output value is register 0. With `cfg_regout`=0 it is the register-0 data input from R1. This gives four output options.
- R7: `pad_out` is the output value XORed with `cfg_invert`.
- R8: `pad_oe` equals `oe_pt`, and `fb_pin` equals `pad_in`, in the same cycle.
- R9: `fb_reg` shows both register values in every output mode, independent of `pad_out`.
- R10: When `preload_en`=1, a clock edge of the register named by `preload_sel` (0 = register 0, 1 = register 1) loads `pad_in` into it, whatever `cfg_invert` is. The other register holds, and D/T logic and preset are ignored.
- R11: While `rst_n`=0, both registers read 0 and `pad_out` equals `cfg_invert` in registered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| sum_term | input | 2 | Sum-term results from the array |
| pt_clk | input | 2 | Per-register clock product terms |
| pin_clk | input | 1 | Dedicated clock pin level |
| arst_pt | input | 2 | Per-register asynchronous reset terms |
| sync_preset | input | 1 | Shared synchronous preset term |
| oe_pt | input | 1 | Output-enable product term |
| cfg_toggle | input | 2 | Per-register toggle mode select |
| cfg_pin_clk | input | 2 | Per-register pin-clock select |
| cfg_regout | input | 1 | Registered (1) or combinatorial (0) output |
| cfg_combine | input | 1 | OR both sum terms into register 0 path |
| cfg_invert | input | 1 | Output polarity inversion |
| preload_en | input | 1 | Test preload mode |
| preload_sel | input | 1 | Register picked for preload |
| pad_in | input | 1 | Level present on the pad |
| pad_out | output | 1 | Value to the pad driver |
| pad_oe | output | 1 | Pad driver enable |
| fb_reg | output | 2 | Register feedback to the array |
| fb_pin | output | 1 | Pad feedback to the array |

## Verification
A wrong register value shows up on `fb_reg` in the cycle after the `clk` edge that stored it. When register 0 drives the pad in registered mode, the same value shows on `pad_out`. A missed or extra clock edge, or a toggle that goes the wrong way, stays visible until the next edge or reset overwrites it. An edge detector with a wrong history can hide for several cycles, and only shows when the source rises. For that reason the reference model is compared on every cycle, over long random runs in each configuration.

// File: rtl/pldmc_pkg.sv
package pldmc_pkg;
    localparam int NREG  = 2;
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

    typedef struct packed {
        logic [NREG-1:0] q;
        logic [NREG-1:0] src_prev;
    } mc_state_t;
endpackage

// File: rtl/pldmc_clk_pick.sv
module pldmc_clk_pick (
    input  logic pt_clk,
    input  logic pin_clk,
    input  logic use_pin,
    input  logic src_prev,
    output logic src_now,
    output logic clk_edge
);
    always_comb begin
        src_now  = use_pin ? pin_clk : pt_clk;
        clk_edge = src_now & ~src_prev;
    end
endmodule

// File: rtl/pldmc_reg_next.sv
module pldmc_reg_next (
    input  logic q,
    input  logic data,
    input  logic clk_edge,
    input  logic t_mode,
    input  logic preset,
    input  logic preload_en,
    input  logic preload_hit,
    input  logic pad_level,
    input  logic arst,
    output logic q_next
);
    always_comb begin
        q_next = q;
        if (clk_edge) begin
            if (preload_en) begin
                q_next = preload_hit ? pad_level : q;
            end else if (preset) begin
                q_next = 1'b1;
            end else if (t_mode) begin
                q_next = q ^ data;
            end else begin
                q_next = data;
            end
        end
        if (arst) begin
            q_next = 1'b0;
        end
    end
endmodule

// File: rtl/pldmc_out_sel.sv
module pldmc_out_sel #(
    parameter int NREG = 2
) (
    input  logic [NREG-1:0] sum_term,
    input  logic            q0_eff,
    input  logic            combine,
    input  logic            registered,
    input  logic            invert,
    output logic [NREG-1:0] reg_data,
    output logic            out_val
);
    logic head_data;

    always_comb begin
        head_data = combine ? (|sum_term) : sum_term[0];
        reg_data  = sum_term;
        reg_data[0] = head_data;
        out_val   = (registered ? q0_eff : head_data) ^ invert;
    end
endmodule

// File: rtl/pldmc_top.sv
module pldmc_top
    import pldmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREG-1:0]  sum_term,
    input  logic [NREG-1:0]  pt_clk,
    input  logic             pin_clk,
    input  logic [NREG-1:0]  arst_pt,
    input  logic             sync_preset,
    input  logic             oe_pt,
    input  logic [NREG-1:0]  cfg_toggle,
    input  logic [NREG-1:0]  cfg_pin_clk,
    input  logic             cfg_regout,
    input  logic             cfg_combine,
    input  logic             cfg_invert,
    input  logic             preload_en,
    input  logic [SEL_W-1:0] preload_sel,
    input  logic             pad_in,
    output logic             pad_out,
    output logic             pad_oe,
    output logic [NREG-1:0]  fb_reg,
    output logic             fb_pin
);
    mc_state_t state_d, state_q;

    logic [NREG-1:0] src_w;
    logic [NREG-1:0] edge_w;
    logic [NREG-1:0] data_w;
    logic [NREG-1:0] qn_w;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        pldmc_clk_pick u_pick (
            .pt_clk   (pt_clk[g]),
            .pin_clk  (pin_clk),
            .use_pin  (cfg_pin_clk[g]),
            .src_prev (state_q.src_prev[g]),
            .src_now  (src_w[g]),
            .clk_edge (edge_w[g])
        );

        pldmc_reg_next u_next (
            .q           (state_q.q[g]),
            .data        (data_w[g]),
            .clk_edge    (edge_w[g]),
            .t_mode      (cfg_toggle[g]),
            .preset      (sync_preset),
            .preload_en  (preload_en),
            .preload_hit (preload_sel == SEL_W'(g)),
            .pad_level   (pad_in),
            .arst        (arst_pt[g]),
            .q_next      (qn_w[g])
        );

        // R4
        arst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            arst_pt[g] |=> !state_q.q[g]);

        // R3
        no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!edge_w[g] && !arst_pt[g]) |=> $stable(state_q.q[g]));

        // R1
        d_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_w[g] && !cfg_toggle[g] && !sync_preset && !preload_en && !arst_pt[g])
            |=> state_q.q[g] == $past(data_w[g]));

        // R5
        preset_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_w[g] && sync_preset && !preload_en && !arst_pt[g]) |=> state_q.q[g]);

        // R10
        preload_other_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (preload_en && preload_sel != SEL_W'(g) && !arst_pt[g])
            |=> $stable(state_q.q[g]));
    end

    pldmc_out_sel #(.NREG(NREG)) u_out (
        .sum_term   (sum_term),
        .q0_eff     (fb_reg[0]),
        .combine    (cfg_combine),
        .registered (cfg_regout),
        .invert     (cfg_invert),
        .reg_data   (data_w),
        .out_val    (pad_out)
    );

    always_comb begin
        state_d          = state_q;
        state_d.q        = qn_w;
        state_d.src_prev = src_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fb_reg = state_q.q & ~arst_pt;
    assign pad_oe = oe_pt;
    assign fb_pin = pad_in;

    // R8
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe == oe_pt);
endmodule

// File: tb/sim_pldmc_top.sv
module sim_pldmc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sum_term = '0, pt_clk = '0, arst_pt = '0;
    logic [1:0] cfg_toggle = '0, cfg_pin_clk = '0;
    logic       pin_clk = 1'b0, sync_preset = 1'b0, oe_pt = 1'b0;
    logic       cfg_regout = 1'b1, cfg_combine = 1'b0, cfg_invert = 1'b1;
    logic       preload_en = 1'b0, preload_sel = 1'b0, pad_in = 1'b0;
    logic       pad_out, pad_oe, fb_pin;
    logic [1:0] fb_reg;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mq[2];
    bit mprev[2];

    always #5 clk = ~clk;

    pldmc_top u0 (
        .clk(clk), .rst_n(rst_n), .sum_term(sum_term), .pt_clk(pt_clk),
        .pin_clk(pin_clk), .arst_pt(arst_pt), .sync_preset(sync_preset),
        .oe_pt(oe_pt), .cfg_toggle(cfg_toggle), .cfg_pin_clk(cfg_pin_clk),
        .cfg_regout(cfg_regout), .cfg_combine(cfg_combine),
        .cfg_invert(cfg_invert), .preload_en(preload_en),
        .preload_sel(preload_sel), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .fb_reg(fb_reg), .fb_pin(fb_pin)
    );

    function automatic bit head_data();
        return cfg_combine ? (sum_term[0] | sum_term[1]) : sum_term[0];
    endfunction

    task automatic check(string tag);
        bit e0, e1, eo;
        e0 = arst_pt[0] ? 1'b0 : mq[0];
        e1 = arst_pt[1] ? 1'b0 : mq[1];
        eo = (cfg_regout ? e0 : head_data()) ^ cfg_invert;
        checks++;
        if (fb_reg !== {e1, e0} || pad_out !== eo || pad_oe !== oe_pt || fb_pin !== pad_in) begin
            errors++;
            $display("FAIL %s: fb_reg=%b pad_out=%b pad_oe=%b fb_pin=%b expected fb_reg=%b pad_out=%b pad_oe=%b fb_pin=%b",
                     tag, fb_reg, pad_out, pad_oe, fb_pin, {e1, e0}, eo, oe_pt, pad_in);
        end
    endtask

    task automatic model_step();
        for (int i = 0; i < 2; i++) begin
            bit src, edg, dat, nq;
            src = cfg_pin_clk[i] ? pin_clk : pt_clk[i];
            edg = src && !mprev[i];
            dat = (i == 0) ? head_data() : sum_term[1];
            nq  = mq[i];
            if (edg) begin
                if (preload_en) nq = (int'(preload_sel) == i) ? pad_in : mq[i];
                else if (sync_preset) nq = 1'b1;
                else if (cfg_toggle[i]) nq = mq[i] ^ dat;
                else nq = dat;
            end
            if (arst_pt[i]) nq = 1'b0;
            mq[i] = nq;
            mprev[i] = src;
        end
    endtask

    task automatic phase(string tag, int n, int p_arst, int p_pre, int p_pl);
        for (int c = 0; c < n; c++) begin
            sum_term    = 2'($urandom);
            pt_clk      = 2'($urandom);
            pin_clk     = 1'($urandom);
            arst_pt[0]  = ($urandom % 100) < p_arst;
            arst_pt[1]  = ($urandom % 100) < p_arst;
            sync_preset = ($urandom % 100) < p_pre;
            preload_en  = ($urandom % 100) < p_pl;
            preload_sel = 1'($urandom);
            pad_in      = 1'($urandom);
            oe_pt       = 1'($urandom);
            #1;
            check(tag);
            model_step();
            @(negedge clk);
        end
    endtask

    task automatic cfg(bit [1:0] tg, bit [1:0] pc, bit ro, bit cb, bit iv);
        cfg_toggle = tg; cfg_pin_clk = pc; cfg_regout = ro;
        cfg_combine = cb; cfg_invert = iv;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mq = '{0, 0};
        mprev = '{0, 0};
        @(negedge clk);
        #1;
        check("R11");
        @(negedge clk);
        rst_n = 1'b1;
        // R1 D mode, product-term clocks, separate terms
        cfg(2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
        phase("R1", 400, 0, 0, 0);
        // R2 toggle mode
        cfg(2'b11, 2'b00, 1'b1, 1'b0, 1'b0);
        phase("R2", 400, 0, 0, 0);
        // R3 pin clock on both, then mixed
        cfg(2'b00, 2'b11, 1'b1, 1'b0, 1'b0);
        phase("R3", 300, 0, 0, 0);
        cfg(2'b10, 2'b01, 1'b1, 1'b1, 1'b0);
        phase("R3", 300, 0, 0, 0);
        // R4 reset against preset and preload
        cfg(2'b01, 2'b10, 1'b1, 1'b0, 1'b1);
        phase("R4", 400, 30, 40, 20);
        // R5 shared preset
        cfg(2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
        phase("R5", 300, 0, 40, 0);
        // R6 four output options
        cfg(2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        phase("R6", 200, 5, 10, 0);
        cfg(2'b00, 2'b00, 1'b0, 1'b1, 1'b0);
        phase("R6", 200, 5, 10, 0);
        cfg(2'b01, 2'b00, 1'b1, 1'b1, 1'b0);
        phase("R6", 200, 5, 10, 0);
        // R7 polarity
        cfg(2'b10, 2'b01, 1'b1, 1'b0, 1'b1);
        phase("R7", 200, 5, 10, 0);
        cfg(2'b00, 2'b00, 1'b0, 1'b1, 1'b1);
        phase("R7", 200, 5, 10, 0);
        // R8 and R9 buried registers in combinatorial output mode
        cfg(2'b11, 2'b10, 1'b0, 1'b0, 1'b0);
        phase("R8 R9", 300, 5, 10, 5);
        // R10 preload with both polarities
        cfg(2'b11, 2'b00, 1'b1, 1'b0, 1'b1);
        phase("R10", 400, 0, 30, 60);
        cfg(2'b00, 2'b11, 1'b1, 1'b1, 1'b0);
        phase("R10", 400, 0, 30, 60);
        // R11 reset again mid-run
        arst_pt = '0;
        cfg(2'b00, 2'b00, 1'b1, 1'b0, 1'b1);
        rst_n = 1'b0;
        mq = '{0, 0};
        mprev = '{0, 0};
        #1;
        check("R11");
        @(negedge clk);
        rst_n = 1'b1;
        phase("R11", 100, 5, 10, 5);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule